// File: doc/BRIEF.md
# Serial-Access Static Memory Slave

This block models a byte-wide static memory that a host reaches over a four-wire SPI link in mode 0, with an extra active-low pause input. The host lowers the select line, shifts in an 8-bit instruction and, for memory access, a 16-bit address, then shifts data in or out. Every field travels most significant bit first. A small mode register chooses how the address moves after each byte. Single-byte access is the default. Page access circles within a 32-byte page. Sequential access runs through the whole array in a fixed order. The same register can switch the pause function off.

All serial inputs are sampled by a fast system clock. Each passes through a two-flop synchronizer, and edges on the serial clock are found by comparing successive synchronized values. The serial clock never clocks any flop. The storage is a synchronous register array written so that block RAM can be inferred. Its capacity is 2^ADDR_W bytes. Set ADDR_W to 13 for the full 8K-byte part. The default is smaller, and the address bits above ADDR_W-1 are ignored.

Top module: `spi_sram_slave`

## Requirements
- R1: The instruction byte decodes as 0x03 memory read, 0x02 memory write, 0x05 mode-register read and 0x01 mode-register write. After any other value the rest of the selected period is ignored: memory is not written and so_oe stays low.
- R2: so_oe is low whenever cs_n is high. so only changes after a falling serial-clock edge, so it holds steady while the serial clock is high.
- R3: A read or write takes a 16-bit address after the instruction. Only its low ADDR_W bits select a byte, and the upper bits have no effect.
- R4: In single-byte mode (mode bits 00) exactly one data byte moves after the address. Later clocks until deselect write nothing, and so_oe stays low during them.
- R5: In page mode (mode bits 10) the address advances by one within its 32-byte page after every byte. It goes from word 31 back to word 0 of the same page and never changes the page bits.
- R6: In sequential mode (mode bits 01) the address advances within the page. When the next word offset would equal the starting offset, it moves to that same offset in the following page. After the last page it continues at page 0, so the top address is followed by 0.
- R7: A mode-register write stores data bits 7:6 as the mode and bit 0 as the pause-disable flag. A read returns {mode, 0000, 1, pause-disable}.
- R8: Mode bits 11 behave exactly like single-byte mode and read back as written.
- R9: Raising cs_n ends any transfer. A byte whose eighth bit has arrived is stored, and a partly shifted byte is dropped.
- R10: When pause is enabled, pulling hold_n low with the serial clock low freezes the transfer. If the clock is high when hold_n falls, the freeze starts at the next falling edge. While frozen, so_oe is low and serial-clock and data activity is ignored. Raising hold_n with the clock low resumes at the same bit.
- R11: With the pause-disable flag set, hold_n has no effect: transfers continue and so_oe stays high.
- R12: Reset sets single-byte mode and enables pause, so the mode register reads 0x02. so_oe is low after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select from the host |
| sck | input | 1 | Serial clock from the host, mode 0 |
| si | input | 1 | Serial data into the block |
| hold_n | input | 1 | Active-low pause request |
| so | output | 1 | Serial data out of the block |
| so_oe | output | 1 | Drive enable for so; the pad is high-impedance when low |

## Verification
The assertions assume that the host keeps each serial-clock phase several system clocks long. They also assume that cs_n and hold_n change only while the serial clock is low and away from its edges, so that a single detected edge stands for each host edge. The stimulus drives every input on the falling system-clock edge and holds each serial-clock phase for six system clocks. It moves cs_n and hold_n only in the low phase, with one deliberate exception: hold_n falls during a high phase to exercise the deferred pause.

// File: rtl/spi_sram_pkg.sv
package spi_sram_pkg;

  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;

  typedef enum logic [1:0] {
    MODE_WORD  = 2'b00,
    MODE_BURST = 2'b01,
    MODE_PAGE  = 2'b10,
    MODE_RSVD  = 2'b11
  } xfer_mode_e;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADDR,
    PH_RDAT,
    PH_WDAT,
    PH_SRD,
    PH_SWR,
    PH_DONE
  } phase_e;

endpackage

// File: rtl/spi_sram_sync.sv
module spi_sram_sync #(
  parameter int          W       = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] sync_q
);

  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
    end
  end

endmodule

// File: rtl/spi_sram_store.sv
module spi_sram_store #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/spi_sram_addr_seq.sv
module spi_sram_addr_seq
  import spi_sram_pkg::*;
#(
  parameter int AW = 11,
  parameter int PW = 5
) (
  input  logic [AW-1:0] cur,
  input  logic [PW-1:0] start_word,
  input  xfer_mode_e    mode,
  output logic [AW-1:0] nxt
);

  localparam int GW = AW - PW;

  logic [PW-1:0] word_inc;
  logic [GW-1:0] page_inc;

  always_comb begin
    word_inc = cur[PW-1:0] + 1'b1;
    page_inc = cur[AW-1:PW] + 1'b1;
    nxt      = {cur[AW-1:PW], word_inc};
    if (mode == MODE_BURST && word_inc == start_word) begin
      nxt = {page_inc, start_word};
    end
  end

endmodule

// File: rtl/spi_sram_hold.sv
module spi_sram_hold (
  input  logic clk,
  input  logic rst,
  input  logic cs_s,
  input  logic sck_s,
  input  logic hold_s,
  input  logic hold_dis,
  output logic held_q,
  output logic hold_lvl
);

  assign hold_lvl = !hold_s && !hold_dis && !cs_s;

  always_ff @(posedge clk) begin
    if (rst || cs_s || hold_dis) begin
      held_q <= 1'b0;
    end else if (!sck_s) begin
      held_q <= !hold_s;
    end
  end

endmodule

// File: rtl/spi_sram_slave.sv
module spi_sram_slave
  import spi_sram_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  output logic so,
  output logic so_oe
);

  localparam int BYTE_W  = 8;
  localparam int CNT_W   = 5;
  localparam int CMD_END = BYTE_W - 1;
  localparam int ADR_END = 2 * BYTE_W - 1;
  localparam int SH_W    = (ADDR_W > BYTE_W) ? ADDR_W - 1 : BYTE_W - 1;

  logic [3:0] pins_s;
  logic       sck_s, si_s, cs_s, hold_s, sck_p;
  logic       held_q, hold_lvl;
  logic       rise, fall, step_en, mem_we;

  phase_e              phase_q;
  logic [CNT_W-1:0]    bcnt_q;
  logic [SH_W-1:0]     shin_q;
  logic [ADDR_W-1:0]   addr_q, addr_nxt;
  logic [PAGE_W-1:0]   start_q;
  xfer_mode_e          mode_q;
  logic                hold_dis_q, op_wr_q, drive_q, so_q, so_oe_q;
  logic [BYTE_W-1:0]   byte_in, rd_q, stat_rd;
  logic [ADDR_W-1:0]   addr_in;

  spi_sram_sync #(.W(4), .RST_VAL(4'b1100)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .din    ({hold_n, cs_n, si, sck}),
    .sync_q (pins_s)
  );

  assign sck_s  = pins_s[0];
  assign si_s   = pins_s[1];
  assign cs_s   = pins_s[2];
  assign hold_s = pins_s[3];

  always_ff @(posedge clk) begin
    if (rst) sck_p <= 1'b0;
    else     sck_p <= sck_s;
  end

  spi_sram_hold u_hold (
    .clk      (clk),
    .rst      (rst),
    .cs_s     (cs_s),
    .sck_s    (sck_s),
    .hold_s   (hold_s),
    .hold_dis (hold_dis_q),
    .held_q   (held_q),
    .hold_lvl (hold_lvl)
  );

  assign rise    = sck_s && !sck_p && !cs_s && !held_q;
  assign fall    = !sck_s && sck_p && !cs_s && !held_q;
  assign byte_in = {shin_q[BYTE_W-2:0], si_s};
  assign addr_in = {shin_q[ADDR_W-2:0], si_s};
  assign stat_rd = {mode_q, 4'b0000, 1'b1, hold_dis_q};
  assign step_en = rise && (phase_q == PH_RDAT || phase_q == PH_WDAT)
                   && bcnt_q == CNT_W'(CMD_END);
  assign mem_we  = step_en && phase_q == PH_WDAT;

  spi_sram_addr_seq #(.AW(ADDR_W), .PW(PAGE_W)) u_seq (
    .cur        (addr_q),
    .start_word (start_q),
    .mode       (mode_q),
    .nxt        (addr_nxt)
  );

  spi_sram_store #(.AW(ADDR_W), .DW(BYTE_W)) u_store (
    .clk   (clk),
    .we    (mem_we),
    .waddr (addr_q),
    .wdata (byte_in),
    .raddr (addr_q),
    .rdata (rd_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_CMD;
      bcnt_q     <= '0;
      shin_q     <= '0;
      addr_q     <= '0;
      start_q    <= '0;
      mode_q     <= MODE_WORD;
      hold_dis_q <= 1'b0;
      op_wr_q    <= 1'b0;
      drive_q    <= 1'b0;
      so_q       <= 1'b0;
      so_oe_q    <= 1'b0;
    end else begin
      so_oe_q <= drive_q && !cs_s && !held_q && !hold_lvl;
      if (cs_s) begin
        phase_q <= PH_CMD;
        bcnt_q  <= '0;
        drive_q <= 1'b0;
      end else begin
        if (rise) begin
          shin_q <= {shin_q[SH_W-2:0], si_s};
          bcnt_q <= bcnt_q + 1'b1;
          case (phase_q)
            PH_CMD: begin
              if (bcnt_q == CNT_W'(CMD_END)) begin
                bcnt_q <= '0;
                case (byte_in)
                  OP_READ:  begin phase_q <= PH_ADDR; op_wr_q <= 1'b0; end
                  OP_WRITE: begin phase_q <= PH_ADDR; op_wr_q <= 1'b1; end
                  OP_RDSR:  phase_q <= PH_SRD;
                  OP_WRSR:  phase_q <= PH_SWR;
                  default:  phase_q <= PH_DONE;
                endcase
              end
            end
            PH_ADDR: begin
              if (bcnt_q == CNT_W'(ADR_END)) begin
                bcnt_q  <= '0;
                addr_q  <= addr_in;
                start_q <= addr_in[PAGE_W-1:0];
                phase_q <= op_wr_q ? PH_WDAT : PH_RDAT;
              end
            end
            PH_RDAT, PH_WDAT: begin
              if (bcnt_q == CNT_W'(CMD_END)) begin
                bcnt_q <= '0;
                addr_q <= addr_nxt;
                if (mode_q inside {MODE_WORD, MODE_RSVD}) begin
                  phase_q <= PH_DONE;
                  drive_q <= 1'b0;
                end
              end
            end
            PH_SRD: begin
              if (bcnt_q == CNT_W'(CMD_END)) begin
                phase_q <= PH_DONE;
                drive_q <= 1'b0;
              end
            end
            PH_SWR: begin
              if (bcnt_q == CNT_W'(CMD_END)) begin
                mode_q     <= xfer_mode_e'(byte_in[7:6]);
                hold_dis_q <= byte_in[0];
                phase_q    <= PH_DONE;
              end
            end
            default: bcnt_q <= bcnt_q;
          endcase
        end
        if (fall) begin
          if (phase_q == PH_RDAT) begin
            so_q    <= rd_q[3'd7 - bcnt_q[2:0]];
            drive_q <= 1'b1;
          end else if (phase_q == PH_SRD) begin
            so_q    <= stat_rd[3'd7 - bcnt_q[2:0]];
            drive_q <= 1'b1;
          end
        end
      end
    end
  end

  assign so    = so_q;
  assign so_oe = so_oe_q;

endmodule

// File: rtl/spi_sram_chk.sv
module spi_sram_chk
  import spi_sram_pkg::*;
#(
  parameter int AW = 11,
  parameter int PW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_s,
  input logic          held_q,
  input logic          hold_lvl,
  input logic          hold_dis_q,
  input logic          so_oe,
  input logic          step_en,
  input logic [4:0]    bcnt_q,
  input logic [AW-1:0] addr_q,
  input phase_e        phase_q,
  input xfer_mode_e    mode_q
);

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> !so_oe); // R2

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_DONE && !cs_s) |=> !so_oe); // R4

  AST_PAGE_KEEPS_PAGE: assert property (@(posedge clk) disable iff (rst)
    (step_en && mode_q == MODE_PAGE) |=> addr_q[AW-1:PW] == $past(addr_q[AW-1:PW])); // R5

  AST_BURST_MOVES: assert property (@(posedge clk) disable iff (rst)
    (step_en && mode_q == MODE_BURST) |=> addr_q != $past(addr_q)); // R6

  AST_HELD_QUIET: assert property (@(posedge clk) disable iff (rst)
    held_q |=> !so_oe); // R10

  AST_HOLD_PIN_QUIET: assert property (@(posedge clk) disable iff (rst)
    hold_lvl |=> !so_oe); // R10

  AST_HELD_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (held_q && !cs_s) |=> $stable(bcnt_q)); // R10

  AST_NO_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    hold_dis_q |=> !held_q); // R11

endmodule

bind spi_sram_slave spi_sram_chk #(.AW(ADDR_W), .PW(PAGE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cs_s       (cs_s),
  .held_q     (held_q),
  .hold_lvl   (hold_lvl),
  .hold_dis_q (hold_dis_q),
  .so_oe      (so_oe),
  .step_en    (step_en),
  .bcnt_q     (bcnt_q),
  .addr_q     (addr_q),
  .phase_q    (phase_q),
  .mode_q     (mode_q)
);

// File: tb/spi_sram_slave_tb.sv
`timescale 1ns/1ps
module spi_sram_slave_tb;

  localparam int AW    = 7;
  localparam int DEPTH = 1 << AW;
  localparam int H     = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic so, so_oe;

  int checks = 0, errors = 0, glitch_cnt = 0;
  bit done = 1'b0;
  logic [7:0] mirror [0:DEPTH-1];
  logic [7:0] wbuf [0:159];
  logic [7:0] rbuf [0:159];
  logic       rany [0:159];

  always #2 clk = ~clk;

  spi_sram_slave #(.ADDR_W(AW), .PAGE_W(5)) u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si),
    .hold_n(hold_n), .so(so), .so_oe(so_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] a, input logic [4:0] s,
                                         input logic [1:0] m);
    logic [4:0] w;
    w = a[4:0] + 5'd1;
    if (m == 2'b01 && w == s) return {a[AW-1:5] + 1'b1, s};
    return {a[AW-1:5], w};
  endfunction

  task automatic bit_io(input logic b, output logic r, output logic oe);
    si = b;
    tick(H);
    r = so; oe = so_oe;
    sck = 1'b1;
    tick(H - 1);
    if (oe && so !== r) glitch_cnt++;
    tick(1);
    sck = 1'b0;
  endtask

  task automatic byte_io(input logic [7:0] tx, output logic [7:0] rx,
                         output logic all_oe, output logic any_oe);
    logic r, oe;
    rx = '0; all_oe = 1'b1; any_oe = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      bit_io(tx[i], r, oe);
      rx = {rx[6:0], r};
      all_oe &= oe; any_oe |= oe;
    end
  endtask

  task automatic sel();
    cs_n = 1'b0; tick(H);
  endtask

  task automatic desel();
    tick(H); cs_n = 1'b1; tick(2 * H);
  endtask

  task automatic hdr(input logic [7:0] op, input logic [15:0] a);
    logic [7:0] rx; logic al, an;
    byte_io(op, rx, al, an);
    byte_io(a[15:8], rx, al, an);
    byte_io(a[7:0], rx, al, an);
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] rx; logic al, an;
    sel(); byte_io(8'h01, rx, al, an); byte_io(v, rx, al, an); desel();
  endtask

  task automatic rdsr(output logic [7:0] v, output logic oe);
    logic [7:0] rx; logic an;
    sel(); byte_io(8'h05, rx, oe, an); byte_io(8'h00, v, oe, an); desel();
  endtask

  task automatic do_write(input logic [15:0] a, input int n, input logic [1:0] m);
    logic [7:0] rx; logic al, an; logic [AW-1:0] p;
    p = a[AW-1:0];
    sel(); hdr(8'h02, a);
    for (int i = 0; i < n; i++) begin
      byte_io(wbuf[i], rx, al, an);
      mirror[p] = wbuf[i];
      p = nxt(p, a[4:0], m);
    end
    desel();
  endtask

  task automatic do_read(input logic [15:0] a, input int n);
    logic al;
    sel(); hdr(8'h03, a);
    for (int i = 0; i < n; i++) byte_io(8'h00, rbuf[i], al, rany[i]);
    desel();
  endtask

  initial begin
    logic [7:0] v, rx; logic oe, r, al, an;
    logic [AW-1:0] p;
    int bad;
    tick(8); rst = 1'b0; tick(4);

    check(so_oe == 1'b0, "R12 oe after reset", so_oe, 0);
    rdsr(v, oe);
    check(v == 8'h02, "R12 mode reg default", v, 8'h02);
    check(oe == 1'b1, "R7 status driven", oe, 1);
    check(so_oe == 1'b0, "R2 deselected oe", so_oe, 0);

    // R6: linear fill in sequential mode, two extra bytes wrap to address 0
    wrsr(8'h40);
    for (int i = 0; i < 130; i++) wbuf[i] = 8'((i * 29 + 11) & 8'hFF);
    do_write(16'h0000, 130, 2'b01);
    do_read(16'h0000, 130);
    bad = 0;
    for (int i = 0; i < 130; i++) if (rbuf[i] !== mirror[i % DEPTH]) bad++;
    check(bad == 0, "R6 full-array walk and top wrap", bad, 0);
    check(mirror[0] == wbuf[128], "R6 wrap overwrote word 0", mirror[0], wbuf[128]);

    // R3: single-byte sweep with upper address bits varied
    wrsr(8'h00);
    for (int a = 0; a < DEPTH; a += 3) begin
      wbuf[0] = 8'((a * 13 + 7) & 8'hFF);
      do_write((a % 2 == 1) ? (16'hE000 | 16'(a)) : 16'(a), 1, 2'b00);
    end
    bad = 0;
    for (int a = 0; a < DEPTH; a += 3) begin
      do_read(16'hFF80 | 16'(a), 1);
      if (rbuf[0] !== mirror[a]) bad++;
    end
    check(bad == 0, "R3 upper address bits ignored", bad, 0);
    check(mirror[3] == 8'd46, "R3 sweep pattern", mirror[3], 46);

    // R4: second byte in single-byte mode
    do_read(16'd10, 2);
    check(rbuf[0] === mirror[10], "R4 first byte", rbuf[0], mirror[10]);
    check(rany[1] == 1'b0, "R4 no drive after one byte", rany[1], 0);
    wbuf[0] = 8'h3C; wbuf[1] = 8'hEE;
    sel(); hdr(8'h02, 16'd22); byte_io(8'h3C, rx, al, an); byte_io(8'hEE, rx, al, an); desel();
    mirror[22] = 8'h3C;
    do_read(16'd23, 1);
    check(rbuf[0] === mirror[23], "R4 second write ignored", rbuf[0], mirror[23]);
    do_read(16'd22, 1);
    check(rbuf[0] === 8'h3C, "R4 first write kept", rbuf[0], 8'h3C);

    // R5: page mode wrap inside page 1
    wrsr(8'h80);
    rdsr(v, oe);
    check(v == 8'h82, "R7 page mode readback", v, 8'h82);
    for (int i = 0; i < 4; i++) wbuf[i] = 8'hA0 + 8'(i);
    do_write(16'h003E, 4, 2'b10);
    check(mirror[32] == 8'hA2, "R5 wrap lands on word 0", mirror[32], 8'hA2);
    do_read(16'h003E, 35);
    bad = 0; p = 7'h3E;
    for (int i = 0; i < 35; i++) begin
      if (rbuf[i] !== mirror[p]) bad++;
      p = nxt(p, 5'd30, 2'b10);
    end
    check(bad == 0, "R5 page read circles", bad, 0);

    // R6: sequential mode starting mid-page
    wrsr(8'h40);
    for (int i = 0; i < 40; i++) wbuf[i] = 8'((i * 7 + 100) & 8'hFF);
    do_write(16'h0050, 40, 2'b01);
    check(mirror[8'h40] == wbuf[16], "R6 wrap to page start", mirror[8'h40], wbuf[16]);
    check(mirror[8'h70] == wbuf[32], "R6 step to next page", mirror[8'h70], wbuf[32]);
    do_read(16'h007D, 6);
    bad = 0; p = 7'h7D;
    for (int i = 0; i < 6; i++) begin
      if (rbuf[i] !== mirror[p]) bad++;
      p = nxt(p, 5'd29, 2'b01);
    end
    check(bad == 0, "R6 read from last page", bad, 0);

    // R8: reserved mode acts as single-byte
    wrsr(8'hC0);
    rdsr(v, oe);
    check(v == 8'hC2, "R8 reserved readback", v, 8'hC2);
    do_read(16'd5, 2);
    check(rbuf[0] === mirror[5], "R8 first byte", rbuf[0], mirror[5]);
    check(rany[1] == 1'b0, "R8 no second byte", rany[1], 0);

    // R9: partial byte dropped at deselect
    wrsr(8'h40);
    sel(); hdr(8'h02, 16'h0030);
    byte_io(8'h11, rx, al, an); byte_io(8'h22, rx, al, an);
    for (int i = 0; i < 3; i++) bit_io(1'b0, r, oe);
    desel();
    mirror[8'h30] = 8'h11; mirror[8'h31] = 8'h22;
    do_read(16'h0030, 3);
    check(rbuf[0] === 8'h11, "R9 byte 0 stored", rbuf[0], 8'h11);
    check(rbuf[1] === 8'h22, "R9 byte 1 stored", rbuf[1], 8'h22);
    check(rbuf[2] === mirror[8'h32], "R9 partial dropped", rbuf[2], mirror[8'h32]);

    // R1: unknown instruction ignored
    sel(); hdr(8'h06, 16'h0010); byte_io(8'h99, rx, al, an); desel();
    check(an == 1'b0, "R1 no drive for unknown op", an, 0);
    do_read(16'h0010, 1);
    check(rbuf[0] === mirror[8'h10], "R1 unknown op no write", rbuf[0], mirror[8'h10]);

    // R10: pause during a read
    wrsr(8'h00);
    sel(); hdr(8'h03, 16'h0033);
    rx = '0;
    for (int i = 0; i < 3; i++) begin bit_io(1'b0, r, oe); rx = {rx[6:0], r}; end
    hold_n = 1'b0; tick(H);
    check(so_oe == 1'b0, "R10 oe off on pause", so_oe, 0);
    repeat (3) begin si = ~si; sck = 1'b1; tick(H); sck = 1'b0; tick(H); end
    check(so_oe == 1'b0, "R10 oe off while paused", so_oe, 0);
    hold_n = 1'b1; tick(H);
    for (int i = 0; i < 5; i++) begin bit_io(1'b0, r, oe); rx = {rx[6:0], r}; end
    desel();
    check(rx === mirror[8'h33], "R10 read resumes at same bit", rx, mirror[8'h33]);

    // R10: pause requested with clock high during a write
    sel(); hdr(8'h02, 16'h0034);
    for (int i = 7; i >= 4; i--) bit_io(v[0] ^ 1'b1 ? 1'((8'hA5 >> i) & 1) : 1'((8'hA5 >> i) & 1), r, oe);
    si = 1'b0; tick(H); sck = 1'b1; tick(H);
    hold_n = 1'b0; tick(2); sck = 1'b0; tick(H);
    repeat (4) begin si = ~si; sck = 1'b1; tick(H); sck = 1'b0; tick(H); end
    hold_n = 1'b1; tick(H);
    for (int i = 2; i >= 0; i--) bit_io(1'((8'hA5 >> i) & 1), r, oe);
    desel();
    mirror[8'h34] = 8'hA5;
    do_read(16'h0034, 1);
    check(rbuf[0] === 8'hA5, "R10 write resumes at same bit", rbuf[0], 8'hA5);

    // R11: pause disabled
    wrsr(8'h01);
    rdsr(v, oe);
    check(v == 8'h03, "R11 disable flag readback", v, 8'h03);
    sel(); hdr(8'h03, 16'h0033);
    rx = '0; al = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (i == 3) hold_n = 1'b0;
      if (i == 5) hold_n = 1'b1;
      bit_io(1'b0, r, oe); rx = {rx[6:0], r}; al &= oe;
    end
    desel();
    check(rx === mirror[8'h33], "R11 hold ignored data", rx, mirror[8'h33]);
    check(al == 1'b1, "R11 oe stays on", al, 1);

    check(glitch_cnt == 0, "R2 so stable while clock high", glitch_cnt, 0);

    // R12: reset restores defaults
    wrsr(8'h81);
    rdsr(v, oe);
    check(v == 8'h83, "R7 page plus disable", v, 8'h83);
    rst = 1'b1; tick(4); rst = 1'b0; tick(4);
    rdsr(v, oe);
    check(v == 8'h02, "R12 defaults after reset", v, 8'h02);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule